// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the time of day for an Ethernet MAC that does precision time stamping. It holds a seconds count and a nanoseconds count. On every clock it adds a programmable step, made of an integer number of nanoseconds and a 24-bit binary fraction of a nanosecond. The fraction builds up in its own accumulator, and each time it overflows one extra nanosecond goes into the count. The nanoseconds count wraps once per second and carries into seconds. The live seconds and nanoseconds are brought out as ports, so that capture logic elsewhere can stamp frames.

Software controls the counter through a flat 32-bit register port with a write strobe, an address and a combinational read-back. The fractional step is written in a swizzled layout into a staging register. It reaches the counter only when the integer step is written. Seconds are written as two halves, straight into the live count with no staging, so software writes the high half first and the low half last. A one-shot signed adjust moves the time forward or back by a nanosecond amount, with a borrow from or a carry into seconds.

Top module: `ptp_tod_timer`

## Requirements
- R1: After reset the seconds, nanoseconds, fraction accumulator and both step registers are zero. All readable registers return zero, and the time holds still until a step is written.
- R2: In a cycle with no write to a time register (nanoseconds, seconds low, seconds high, adjust), the fraction accumulator gains the committed 24-bit fraction. The nanoseconds gain the integer step plus one when that fraction sum overflows 2^24.
- R3: When nanoseconds reach NS_PER_SEC they wrap, keeping the remainder, and seconds go up by one. A 48-bit seconds count of all ones wraps to zero.
- R4: The fractional step register (address 3) maps write bits [15:0] to fraction bits [23:8] and write bits [31:24] to fraction bits [7:0]. A read of address 3 returns the committed fraction in the same layout, with bits [23:16] zero.
- R5: A write to address 3 only stages the fraction. The counter and the read-back keep the old fraction until address 4 (integer step, bits [7:0]) is written, and that write commits the staged fraction.
- R6: A write to address 2 (bits [15:0]) replaces seconds [47:32], and a write to address 1 replaces seconds [31:0]. Each takes effect at once, leaves the other half alone, and suspends the step for that cycle.
- R7: A write to address 0 loads the nanoseconds directly. The step is suspended for that cycle.
- R8: A write to address 5 with bit 31 clear adds bits [29:0] (less than one second) to the nanoseconds, carrying one into seconds when the sum reaches NS_PER_SEC. The step is suspended for that cycle.
- R9: A write to address 5 with bit 31 set subtracts bits [29:0] from the nanoseconds. When the result would go below zero it adds NS_PER_SEC and borrows one from seconds.
- R10: With both step registers zero, the time does not change.
- R11: Reads return the live value of the addressed register in the same cycle, with nanoseconds at address 0 and seconds in halves at addresses 1 and 2. Addresses 5 to 7 read zero, and writes to 6 and 7 leave the time advancing normally.
- R12: A write to either step register does not disturb the step of that same cycle, which still uses the previous step. The new step applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Live read data of the addressed register |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | NS_W (30) | Current nanoseconds |

## Verification
The bench builds the block with NS_PER_SEC set to 1000, so a nanoseconds field of 10 bits. At a step of about seven nanoseconds, a second passes in roughly 140 cycles. Wraps into seconds, carries out of the fraction and adjusts across the second boundary all come up many times in a short run. Seconds keep their full 48-bit default, and the bench reaches the top-of-range wrap by writing the seconds halves to all ones.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam int FRAC_W     = 24;
    localparam int REG_W      = 32;
    localparam int SEC_LO_W   = 32;
    localparam int ADJ_MAG_W  = 30;
    localparam int ADJ_SIGN_B = 31;

    typedef enum logic [2:0] {
        SEL_NSEC    = 3'd0,
        SEL_SEC_LO  = 3'd1,
        SEL_SEC_HI  = 3'd2,
        SEL_INC_SUB = 3'd3,
        SEL_INC_INT = 3'd4,
        SEL_ADJUST  = 3'd5,
        SEL_RSVD6   = 3'd6,
        SEL_RSVD7   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    // packed argument: {write bits [31:24], write bits [15:0]}
    function automatic logic [FRAC_W-1:0] frac_from_reg(input logic [23:0] p);
        return {p[15:0], p[23:16]};
    endfunction

    function automatic logic [REG_W-1:0] frac_to_reg(input logic [FRAC_W-1:0] f);
        return {f[7:0], 8'h00, f[23:8]};
    endfunction

endpackage

// File: rtl/ptp_incr_regs.sv
module ptp_incr_regs
    import ptp_tod_pkg::*;
#(
    parameter int INC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_we,
    input  logic              int_we,
    input  logic [23:0]       sub_field,
    input  logic [INC_W-1:0]  int_field,
    output logic [INC_W-1:0]  inc_int,
    output logic [FRAC_W-1:0] inc_frac
);

    logic [FRAC_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            inc_int  <= '0;
            inc_frac <= '0;
        end else begin
            if (sub_we) begin
                pend_q <= frac_from_reg(sub_field);
            end
            if (int_we) begin
                inc_int  <= int_field;
                inc_frac <= pend_q;
            end
        end
    end

    // R5
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !int_we |=> ($stable(inc_int) && $stable(inc_frac)));

    // R5
    sub_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_we && !int_we) |=> $stable(inc_frac));

endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
    import ptp_tod_pkg::*;
#(
    parameter int NS_PER_SEC = 1_000_000_000,
    parameter int NS_W       = $clog2(NS_PER_SEC),
    parameter int SEC_W      = 48,
    parameter int INC_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           cmd,
    input  logic [INC_W-1:0]  inc_int,
    input  logic [FRAC_W-1:0] inc_frac,
    output logic [SEC_W-1:0]  sec,
    output logic [NS_W-1:0]   ns
);

    localparam int SEC_HI_W = SEC_W - SEC_LO_W;
    localparam logic [31:0] NSPS = 32'(NS_PER_SEC);

    logic [FRAC_W-1:0] frac_q, frac_n;
    logic [NS_W-1:0]   ns_q, ns_n;
    logic [SEC_W-1:0]  sec_q, sec_n;

    logic [FRAC_W:0]   frac_sum;
    logic [31:0]       step_ns, adv_ns;
    logic              step_wrap;
    logic [31:0]       adj_mag, adj_up, adj_dn, adj_ns;
    logic              adj_carry, adj_borrow;
    logic [SEC_W-1:0]  adj_sec;
    logic              time_wr;

    always_comb begin
        frac_sum  = {1'b0, frac_q} + {1'b0, inc_frac};
        step_ns   = 32'(ns_q) + 32'(inc_int) + 32'(frac_sum[FRAC_W]);
        step_wrap = (step_ns >= NSPS);
        adv_ns    = step_wrap ? (step_ns - NSPS) : step_ns;

        adj_mag    = {2'b00, cmd.data[ADJ_MAG_W-1:0]};
        adj_up     = 32'(ns_q) + adj_mag;
        adj_carry  = (adj_up >= NSPS);
        adj_dn     = 32'(ns_q) - adj_mag;
        adj_borrow = (32'(ns_q) < adj_mag);
        if (cmd.data[ADJ_SIGN_B]) begin
            adj_ns  = adj_borrow ? (adj_dn + NSPS) : adj_dn;
            adj_sec = sec_q - SEC_W'(adj_borrow);
        end else begin
            adj_ns  = adj_carry ? (adj_up - NSPS) : adj_up;
            adj_sec = sec_q + SEC_W'(adj_carry);
        end

        frac_n  = frac_sum[FRAC_W-1:0];
        ns_n    = adv_ns[NS_W-1:0];
        sec_n   = sec_q + SEC_W'(step_wrap);
        time_wr = 1'b0;
        if (cmd.en) begin
            unique case (cmd.sel)
                SEL_NSEC: begin
                    time_wr = 1'b1;
                    frac_n  = frac_q;
                    ns_n    = cmd.data[NS_W-1:0];
                    sec_n   = sec_q;
                end
                SEL_SEC_LO: begin
                    time_wr = 1'b1;
                    frac_n  = frac_q;
                    ns_n    = ns_q;
                    sec_n   = {sec_q[SEC_W-1:SEC_LO_W], cmd.data};
                end
                SEL_SEC_HI: begin
                    time_wr = 1'b1;
                    frac_n  = frac_q;
                    ns_n    = ns_q;
                    sec_n   = {cmd.data[SEC_HI_W-1:0], sec_q[SEC_LO_W-1:0]};
                end
                SEL_ADJUST: begin
                    time_wr = 1'b1;
                    frac_n  = frac_q;
                    ns_n    = adj_ns[NS_W-1:0];
                    sec_n   = adj_sec;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            ns_q   <= '0;
            sec_q  <= '0;
        end else begin
            frac_q <= frac_n;
            ns_q   <= ns_n;
            sec_q  <= sec_n;
        end
    end

    assign sec = sec_q;
    assign ns  = ns_q;

    // R3
    ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(ns_q) < NSPS);

    // R10
    stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_int == '0 && inc_frac == '0 && !time_wr)
        |=> ($stable(ns_q) && $stable(sec_q)));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        !time_wr |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1)));

    // R6
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.en && cmd.sel == SEL_SEC_HI)
        |=> (sec_q[SEC_LO_W-1:0] == $past(sec_q[SEC_LO_W-1:0])));

endmodule

// File: rtl/ptp_rd_mux.sv
module ptp_rd_mux
    import ptp_tod_pkg::*;
#(
    parameter int NS_W  = 30,
    parameter int SEC_W = 48,
    parameter int INC_W = 8
) (
    input  reg_sel_e          sel,
    input  logic [NS_W-1:0]   ns,
    input  logic [SEC_W-1:0]  sec,
    input  logic [INC_W-1:0]  inc_int,
    input  logic [FRAC_W-1:0] inc_frac,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        unique case (sel)
            SEL_NSEC:    rdata = REG_W'(ns);
            SEL_SEC_LO:  rdata = sec[SEC_LO_W-1:0];
            SEL_SEC_HI:  rdata = REG_W'(sec[SEC_W-1:SEC_LO_W]);
            SEL_INC_SUB: rdata = frac_to_reg(inc_frac);
            SEL_INC_INT: rdata = REG_W'(inc_int);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptp_tod_timer.sv
module ptp_tod_timer
    import ptp_tod_pkg::*;
#(
    parameter int NS_PER_SEC = 1_000_000_000,
    parameter int NS_W       = $clog2(NS_PER_SEC),
    parameter int SEC_W      = 48,
    parameter int INC_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [SEC_W-1:0] tod_sec,
    output logic [NS_W-1:0]  tod_ns
);

    reg_wr_t           cmd;
    logic [INC_W-1:0]  inc_int;
    logic [FRAC_W-1:0] inc_frac;
    logic              sub_we, int_we;

    always_comb begin
        cmd.en   = reg_wr;
        cmd.sel  = reg_sel_e'(reg_addr);
        cmd.data = reg_wdata;
        sub_we   = reg_wr && (cmd.sel == SEL_INC_SUB);
        int_we   = reg_wr && (cmd.sel == SEL_INC_INT);
    end

    ptp_incr_regs #(.INC_W(INC_W)) u_incr (
        .clk       (clk),
        .rst       (rst),
        .sub_we    (sub_we),
        .int_we    (int_we),
        .sub_field ({reg_wdata[31:24], reg_wdata[15:0]}),
        .int_field (reg_wdata[INC_W-1:0]),
        .inc_int   (inc_int),
        .inc_frac  (inc_frac)
    );

    ptp_tod_core #(
        .NS_PER_SEC (NS_PER_SEC),
        .NS_W       (NS_W),
        .SEC_W      (SEC_W),
        .INC_W      (INC_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .inc_int  (inc_int),
        .inc_frac (inc_frac),
        .sec      (tod_sec),
        .ns       (tod_ns)
    );

    ptp_rd_mux #(
        .NS_W  (NS_W),
        .SEC_W (SEC_W),
        .INC_W (INC_W)
    ) u_rd (
        .sel      (cmd.sel),
        .ns       (tod_ns),
        .sec      (tod_sec),
        .inc_int  (inc_int),
        .inc_frac (inc_frac),
        .rdata    (reg_rdata)
    );

endmodule

// File: tb/ptp_tod_timer_tb_top.sv
`timescale 1ns/1ps
module ptp_tod_timer_tb_top;

    localparam int NSPS  = 1000;
    localparam int NS_W  = 10;
    localparam int SEC_W = 48;
    localparam longint unsigned SMASK = (64'd1 << 48) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [SEC_W-1:0] tod_sec;
    logic [NS_W-1:0]  tod_ns;

    always #2.5 clk = ~clk;

    ptp_tod_timer #(.NS_PER_SEC(NSPS), .NS_W(NS_W), .SEC_W(SEC_W), .INC_W(8)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    // behavioural reference state
    longint unsigned m_sec;
    longint          m_ns, m_frac, m_int, m_com, m_pend;
    int    errs = 0, checks = 0, cyc = 0;
    string ph = "R1";
    bit    done = 0;

    task automatic m_step();
        longint c;
        m_frac = m_frac + m_com;
        c      = m_frac >> 24;
        m_frac = m_frac & 64'hFF_FFFF;
        m_ns   = m_ns + m_int + c;
        if (m_ns >= NSPS) begin
            m_ns  = m_ns - NSPS;
            m_sec = (m_sec + 1) & SMASK;
        end
    endtask

    always @(posedge clk) begin
        longint mag;
        if (rst) begin
            m_sec = 0; m_ns = 0; m_frac = 0; m_int = 0; m_com = 0; m_pend = 0;
        end else if (reg_wr && reg_addr == 3'd0) begin
            m_ns = longint'(reg_wdata);
        end else if (reg_wr && reg_addr == 3'd1) begin
            m_sec = (m_sec & 64'hFFFF_0000_0000) | longint'(reg_wdata);
        end else if (reg_wr && reg_addr == 3'd2) begin
            m_sec = ((longint'(reg_wdata) & 64'hFFFF) << 32) | (m_sec & 64'hFFFF_FFFF);
        end else if (reg_wr && reg_addr == 3'd5) begin
            mag = longint'(reg_wdata) & 64'h3FFF_FFFF;
            if (reg_wdata[31]) begin
                m_ns = m_ns - mag;
                if (m_ns < 0) begin m_ns = m_ns + NSPS; m_sec = (m_sec - 1) & SMASK; end
            end else begin
                m_ns = m_ns + mag;
                if (m_ns >= NSPS) begin m_ns = m_ns - NSPS; m_sec = (m_sec + 1) & SMASK; end
            end
        end else begin
            m_step();
            if (reg_wr && reg_addr == 3'd3)
                m_pend = ((longint'(reg_wdata) & 64'hFFFF) << 8) | ((longint'(reg_wdata) >> 24) & 64'hFF);
            if (reg_wr && reg_addr == 3'd4) begin
                m_int = longint'(reg_wdata) & 64'hFF;
                m_com = m_pend;
            end
        end
    end

    // every-cycle comparison of the live time
    always @(posedge clk) begin
        #1;
        checks++;
        if (tod_ns !== NS_W'(m_ns) || tod_sec !== SEC_W'(m_sec)) begin
            errs++;
            $display("FAIL %s: time sec=%0d ns=%0d expected sec=%0d ns=%0d",
                     ph, tod_sec, tod_ns, m_sec, m_ns);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            errs++;
            checks++;
            $display("FAIL watchdog (all R): cycles=%0d expected < 50000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    function automatic logic [31:0] exp_rd(input int a);
        case (a)
            0: return 32'(m_ns);
            1: return 32'(m_sec & 64'hFFFF_FFFF);
            2: return 32'(m_sec >> 32);
            3: return 32'(((m_com & 64'hFF) << 24) | (m_com >> 8));
            4: return 32'(m_int);
            default: return 32'd0;
        endcase
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_lit(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'(a);
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errs++;
            $display("FAIL %s: read addr %0d got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic rd_live(input int a, input string req);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'(a);
        #1;
        checks++;
        if (reg_rdata !== exp_rd(a)) begin
            errs++;
            $display("FAIL %s: live read addr %0d got %h expected %h", req, a, reg_rdata, exp_rd(a));
        end
    endtask

    initial begin
        ph = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 8; a++) rd_lit(a, 32'd0, "R1");
        ph = "R10"; idle(5);

        // stage a fraction of 0x4000A5: write bits [15:0]=0x4000, [31:24]=0xA5
        ph = "R5"; wr(3, 32'hA500_4000);
        idle(3);
        rd_lit(3, 32'd0, "R5");
        rd_lit(0, 32'd0, "R5");

        ph = "R12"; wr(4, 32'd7);
        rd_lit(3, 32'hA500_4000, "R4");
        rd_lit(4, 32'd7, "R5");

        ph = "R2"; idle(50);
        ph = "R3"; idle(350);
        rd_live(0, "R11");
        rd_live(1, "R11");

        ph = "R7"; wr(0, 32'd990); idle(4);

        // seconds written high then low, near the top of the range
        ph = "R6"; wr(0, 32'd0);
        wr(2, 32'h0000_FFFF);
        rd_lit(2, 32'h0000_FFFF, "R6");
        wr(1, 32'hFFFF_FFFF);
        rd_lit(1, 32'hFFFF_FFFF, "R6");
        ph = "R3"; wr(0, 32'd995); idle(4);
        rd_lit(2, 32'd0, "R3");
        rd_lit(1, 32'd0, "R3");

        ph = "R8"; wr(0, 32'd100); wr(5, 32'd600); wr(5, 32'd600); idle(2);
        ph = "R9"; wr(5, 32'h8000_0000 | 32'd900); wr(5, 32'h8000_0000 | 32'd900); idle(2);
        wr(0, 32'd5); wr(5, 32'h8000_0000 | 32'd999); idle(2);
        rd_lit(5, 32'd0, "R11");

        ph = "R11"; wr(6, 32'hFFFF_FFFF); wr(7, 32'h1234_5678);
        rd_lit(6, 32'd0, "R11");
        rd_lit(7, 32'd0, "R11");
        rd_live(0, "R11");

        ph = "R12"; wr(3, 32'h0000_8000); wr(4, 32'd3); idle(20);
        rd_lit(3, 32'h0000_8000, "R4");

        ph = "R10"; wr(3, 32'd0); wr(4, 32'd0); idle(10);
        rd_live(0, "R10");
        rd_lit(4, 32'd0, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule